// File: doc/BRIEF.md
# Two-Bank GPIO Register Controller

This block is a memory-mapped general-purpose I/O controller for thirty-two pins arranged as two banks of sixteen. One 32-bit register holds both banks: the lower bank sits in bits 15:0 and the upper bank in bits 31:16. Software reaches it through a plain synchronous register bus. The bus has a byte address, write data, a write strobe, a read strobe and read data. Per pin, software can choose the direction, write the drive value directly, or change only some bits. A write-one-to-set offset and a write-one-to-clear offset change only the bits written as one. Because of this, independent firmware threads can toggle their own pins without any lock.

On the pin side, the block drives an output-enable vector and an output-value vector. It receives the pad input vector back, passed through a two-flop synchronizer. The output register always reads back the value being driven, and the input register always reads back the synchronized pin state. Together these let software build wired logic on open-drain pads.

Each bus access is first classified by an address decoder into one of seven named selections:
- `SEL_ID`, `SEL_DIR`, `SEL_OUT`, `SEL_SET`, `SEL_CLR` and `SEL_IN` each name one mapped register.
- `SEL_NONE` covers every other address.

The selection held during a cycle decides which register a write strobe updates and which value a read strobe captures.

Top module: `gpio_pair_ctrl`

## Requirements
- R1: After reset, the direction register is all ones, so `pin_oe` is 0x00000000. `pin_out` is zero and `bus_rdata` is zero.
- R2: A write to offset 0x10 loads the direction register. A direction bit of 1 makes the pin an input, with `pin_oe` bit 0. A bit of 0 makes it an output, with `pin_oe` bit 1. Bit n controls pin n, for example bit 16 is pin 0 of the upper bank. Reading 0x10 returns the register.
- R3: A write to offset 0x14 replaces all 32 bits of the output register. The new value is on `pin_out` after the write edge, and it reads back at 0x14 whatever the direction setting.
- R4: A write to offset 0x18 sets to 1 every output bit written as 1. Bits written as 0 keep their value.
- R5: A write to offset 0x1C clears to 0 every output bit written as 1. Bits written as 0 keep their value.
- R6: Reading offset 0x18 or 0x1C returns the current output register value.
- R7: Reading offset 0x20 returns the synchronized `pin_in` value for all pins, inputs and outputs alike. Writes to 0x20 change nothing.
- R8: Offset 0x00 reads the identification constant 0x47500102. Writes to it change nothing.
- R9: Any other address, including unaligned ones such as 0x13, reads as zero. A write to it changes no register.
- R10: `bus_rdata` is loaded on a clock edge where `bus_rd` is high and holds its value otherwise. A read and a write to the same offset in the same cycle return the value from before the write.
- R11: The input path has exactly two synchronizer flops. A pin change made before edge A is still old in a read captured at edge B, the next edge. It is new in a read captured at edge C, the one after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Pad input values |
| pin_oe | output | 32 | Output enable per pin, 1 = drive |
| pin_out | output | 32 | Output drive value per pin |

## Verification
A read and a write can hit the same register in the same cycle. The bench provokes this by raising both strobes together on the output data offset with a new value. It judges the result by requiring the old value in that read and the new value in the read after it. A pad change can also race the synchronizer against an ongoing read of the input offset. The bench holds the read strobe across three consecutive edges and compares each captured word with the old and new pin values in the order that the two-flop delay requires.

// File: rtl/gpio_pair_pkg.sv
package gpio_pair_pkg;

    localparam int unsigned BANK_PINS   = 16;
    localparam int unsigned BANK_COUNT  = 2;
    localparam int unsigned GPIO_W      = BANK_PINS * BANK_COUNT;
    localparam int unsigned ADDR_W      = 8;
    localparam int unsigned SYNC_STAGES = 2;

    localparam logic [GPIO_W-1:0] ID_VALUE = 32'h4750_0102;

    localparam logic [ADDR_W-1:0] OFS_ID  = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_DIR = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_OUT = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_SET = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_CLR = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_IN  = 8'h20;

    typedef enum logic [2:0] {
        SEL_NONE = 3'd0,
        SEL_ID   = 3'd1,
        SEL_DIR  = 3'd2,
        SEL_OUT  = 3'd3,
        SEL_SET  = 3'd4,
        SEL_CLR  = 3'd5,
        SEL_IN   = 3'd6
    } reg_sel_e;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync
    import gpio_pair_pkg::*;
#(
    parameter int unsigned WIDTH  = GPIO_W,
    parameter int unsigned STAGES = SYNC_STAGES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q[0] <= '0;
        end else begin
            stage_q[0] <= async_in;
        end
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_chain
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage_q[s] <= '0;
            end else begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_pair_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);

    always_comb begin
        unique case (addr)
            OFS_ID:  sel = SEL_ID;
            OFS_DIR: sel = SEL_DIR;
            OFS_OUT: sel = SEL_OUT;
            OFS_SET: sel = SEL_SET;
            OFS_CLR: sel = SEL_CLR;
            OFS_IN:  sel = SEL_IN;
            default: sel = SEL_NONE;
        endcase
    end

endmodule

// File: rtl/gpio_out_regs.sv
module gpio_out_regs
    import gpio_pair_pkg::*;
#(
    parameter int unsigned WIDTH = GPIO_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dir_we,
    input  logic             out_we,
    input  logic             set_en,
    input  logic             clr_en,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] out_q
);

    logic [WIDTH-1:0] set_mask;
    logic [WIDTH-1:0] clr_mask;

    always_comb begin
        set_mask = set_en ? wdata : '0;
        clr_mask = clr_en ? wdata : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= '1;
        end else if (dir_we) begin
            dir_q <= wdata;
        end
    end

    // clear is applied last so it dominates a coincident set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else if (out_we) begin
            out_q <= wdata;
        end else begin
            out_q <= (out_q | set_mask) & ~clr_mask;
        end
    end

    a_r4_set: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && !clr_en && !out_we) |=> ((out_q & $past(wdata)) == $past(wdata)));

    a_r5_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !out_we) |=> ((out_q & $past(wdata)) == '0));

    a_r4_keep: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_en || clr_en) && !out_we)
        |=> (((out_q ^ $past(out_q)) & ~$past(wdata)) == '0));

    a_r2_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !dir_we |=> $stable(dir_q));

endmodule

// File: rtl/gpio_pair_ctrl.sv
module gpio_pair_ctrl
    import gpio_pair_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [GPIO_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [GPIO_W-1:0] bus_rdata,
    input  logic [GPIO_W-1:0] pin_in,
    output logic [GPIO_W-1:0] pin_oe,
    output logic [GPIO_W-1:0] pin_out
);

    reg_sel_e          sel;
    logic [GPIO_W-1:0] dir_q;
    logic [GPIO_W-1:0] out_q;
    logic [GPIO_W-1:0] in_sync;
    logic [GPIO_W-1:0] rd_mux;

    gpio_addr_decode u_decode (
        .addr (bus_addr),
        .sel  (sel)
    );

    gpio_out_regs #(.WIDTH(GPIO_W)) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .dir_we (bus_wr && (sel == SEL_DIR)),
        .out_we (bus_wr && (sel == SEL_OUT)),
        .set_en (bus_wr && (sel == SEL_SET)),
        .clr_en (bus_wr && (sel == SEL_CLR)),
        .wdata  (bus_wdata),
        .dir_q  (dir_q),
        .out_q  (out_q)
    );

    gpio_in_sync #(.WIDTH(GPIO_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (in_sync)
    );

    always_comb begin
        unique case (sel)
            SEL_ID:                    rd_mux = ID_VALUE;
            SEL_DIR:                   rd_mux = dir_q;
            SEL_OUT, SEL_SET, SEL_CLR: rd_mux = out_q;
            SEL_IN:                    rd_mux = in_sync;
            default:                   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_mux;
        end
    end

    assign pin_oe  = ~dir_q;
    assign pin_out = out_q;

    a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (sel == SEL_NONE)) |=> (bus_rdata == '0));

    a_r8_id_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (sel == SEL_ID)) |=> (bus_rdata == ID_VALUE));

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    a_r9_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && ((sel == SEL_NONE) || (sel == SEL_IN) || (sel == SEL_ID)))
        |=> ($stable(pin_out) && $stable(pin_oe)));

    a_r6_set_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && ((sel == SEL_SET) || (sel == SEL_CLR)))
        |=> (bus_rdata == pin_out));

endmodule

// File: tb/gpio_pair_ctrl_tb_top.sv
module gpio_pair_ctrl_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_oe;
    logic [31:0] pin_out;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    gpio_pair_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_oe    (pin_oe),
        .pin_out   (pin_out)
    );

    // fields: {req, addr, wdata, expected output register}
    localparam int NV = 11;
    localparam logic [79:0] VEC [NV] = '{
        {8'd3, 8'h14, 32'hA5A5_0F0F, 32'hA5A5_0F0F},  // R3 direct write
        {8'd4, 8'h18, 32'h0000_F0F0, 32'hA5A5_FFFF},  // R4 set
        {8'd5, 8'h1C, 32'hA5A5_0000, 32'h0000_FFFF},  // R5 clear
        {8'd4, 8'h18, 32'h0000_0000, 32'h0000_FFFF},  // R4 zeros keep
        {8'd5, 8'h1C, 32'h0000_0000, 32'h0000_FFFF},  // R5 zeros keep
        {8'd4, 8'h18, 32'hFFFF_0000, 32'hFFFF_FFFF},  // R4 upper bank
        {8'd5, 8'h1C, 32'h0000_8001, 32'hFFFF_7FFE},  // R5 bank edges
        {8'd7, 8'h20, 32'h0000_1234, 32'hFFFF_7FFE},  // R7 input write ignored
        {8'd9, 8'h04, 32'h0000_0000, 32'hFFFF_7FFE},  // R9 unmapped write ignored
        {8'd8, 8'h00, 32'h0000_0000, 32'hFFFF_7FFE},  // R8 id write ignored
        {8'd3, 8'h14, 32'h0000_0000, 32'h0000_0000}   // R3 direct clear all
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        v = bus_rdata;
    endtask

    initial begin
        #(200000 * 4);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 oe", pin_oe, 32'h0);
        check("R1 out", pin_out, 32'h0);
        check("R1 rdata", bus_rdata, 32'h0);
        bus_read(8'h10, v);
        check("R1 dir", v, 32'hFFFF_FFFF);

        // table walk: R3 R4 R5 R6 R7 R8 R9
        for (int i = 0; i < NV; i++) begin
            bus_write(VEC[i][71:64], VEC[i][63:32]);
            check($sformatf("R%0d pin_out vec%0d", VEC[i][79:72], i), pin_out, VEC[i][31:0]);
            bus_read(8'h14, v);
            check($sformatf("R%0d readback vec%0d", VEC[i][79:72], i), v, VEC[i][31:0]);
            bus_read(8'h18, v);
            check("R6 set-offset read", v, VEC[i][31:0]);
            bus_read(8'h1C, v);
            check("R6 clr-offset read", v, VEC[i][31:0]);
        end

        // R8 identification
        bus_read(8'h00, v);
        check("R8 id", v, 32'h4750_0102);

        // R2 direction
        bus_write(8'h10, 32'h0000_FFFF);
        check("R2 oe upper bank", pin_oe, 32'hFFFF_0000);
        bus_read(8'h10, v);
        check("R2 dir readback", v, 32'h0000_FFFF);

        // R3 output readback independent of direction
        bus_write(8'h14, 32'h1357_9BDF);
        bus_read(8'h14, v);
        check("R3 readback with mixed dir", v, 32'h1357_9BDF);

        // R7 input read regardless of direction
        @(negedge clk);
        pin_in = 32'hC3C3_5A5A;
        repeat (3) @(negedge clk);
        bus_read(8'h20, v);
        check("R7 input data", v, 32'hC3C3_5A5A);

        // R9 unmapped and unaligned reads
        bus_read(8'h04, v);
        check("R9 read 0x04", v, 32'h0);
        bus_read(8'h13, v);
        check("R9 read 0x13", v, 32'h0);
        bus_read(8'h24, v);
        check("R9 read 0x24", v, 32'h0);

        // R10 hold without read strobe
        bus_read(8'h00, v);
        @(negedge clk);
        bus_addr = 8'h04;
        repeat (2) @(negedge clk);
        check("R10 hold", bus_rdata, 32'h4750_0102);

        // R10 read and write same offset same cycle
        @(negedge clk);
        bus_addr = 8'h14; bus_wdata = 32'hDEAD_BEEF; bus_wr = 1'b1; bus_rd = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        check("R10 old value on collision", bus_rdata, 32'h1357_9BDF);
        bus_read(8'h14, v);
        check("R10 new value after collision", v, 32'hDEAD_BEEF);

        // R11 synchronizer latency
        @(negedge clk);
        pin_in = 32'h0F0F_F0F0;
        bus_addr = 8'h20; bus_rd = 1'b1;
        @(negedge clk);
        check("R11 edge A old", bus_rdata, 32'hC3C3_5A5A);
        @(negedge clk);
        check("R11 edge B old", bus_rdata, 32'hC3C3_5A5A);
        @(negedge clk);
        check("R11 edge C new", bus_rdata, 32'h0F0F_F0F0);
        bus_rd = 1'b0;

        // R1 reset again restores defaults
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check("R1 oe after reset", pin_oe, 32'h0);
        check("R1 out after reset", pin_out, 32'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule